// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit executes the memory transfer instructions of a 32-bit load/store core. The issue stage presents the primary opcode, a sub-code, the destination register index and the raw offset field, along with the current values of Rj, R13, R14 and R15. The unit decodes the access size and addressing form and computes the effective address. It then issues one memory request with byte enables and lane-placed store data, and on completion returns a zero-extended load value, the new stack pointer for the push and pop forms, and new condition flags when the status word is popped.

Only one instruction is in flight at a time. A legal instruction is latched in the cycle it is accepted, so the register operand inputs may change afterwards. The request is held steady until memory signals ready. In the following cycle a one-cycle completion pulse carries every writeback value. Memory is big-endian, meaning address offset 0 maps to bits [31:24].

Top module: `lsu_unit`

## Requirements
- R1: After reset `iss_ready`=1, `mem_req`=0 and `done`=0. A legal instruction seen with `iss_valid`=1 while `iss_ready`=1 raises `mem_req` in the next cycle and lowers `iss_ready`. Address, byte enables, write data and `mem_we` then stay unchanged until `mem_ready` is sampled high. `done` is high for exactly the one cycle after that edge, and `mem_req` is low in that cycle.
- R2: Opcodes 0x04/0x05/0x06 (load word/half/byte) and 0x14/0x15/0x16 (store) address memory at Rj. Opcodes 0x00/0x01/0x02 (load) and 0x10/0x11/0x12 (store) address memory at R13+Rj.
- R3: When `iss_opc[7:4]` is 2..7, the access is R14-relative: 2/3 word load/store, 4/5 halfword load/store, 6/7 byte load/store. The address is R14 plus the sign-extended 8-bit `iss_off`, shifted left by 2 for a word, by 1 for a halfword and by 0 for a byte.
- R4: Opcodes 0x03 (load) and 0x13 (store) are word accesses at R15 plus `iss_off[3:0]`, zero-extended and multiplied by 4.
- R5: Opcode 0x07 with `iss_sub`=0 pops a word. It reads at R15, writes the loaded word to register `iss_ri`, and completes with `sp_we`=1 and `sp_data`=R15+4.
- R6: Opcode 0x17 with `iss_sub`=0 pushes a word. It writes `ri_val` at R15-4 and completes with `sp_we`=1 and `sp_data`=R15-4. No other form asserts `sp_we`.
- R7: A halfword address has bit 0 cleared, and a word address has bits [1:0] cleared, before it is issued. No error is raised.
- R8: Byte lanes are big-endian. A byte access at offset a has `mem_be`=4'b1000>>a and write data equal to the source byte replicated four times. A halfword has `mem_be`=4'b1100 at offset 0 and 4'b0011 at offset 2, with the halfword replicated twice. A word has `mem_be`=4'hF. A store drives `mem_we`=1 and completes with `wb_we`=0.
- R9: A load completes with `wb_we`=1 and `wb_idx`=`iss_ri`. Byte loads zero-extend the addressed byte lane, and halfword loads zero-extend the addressed halfword lane.
- R10: Opcode 0x07 with `iss_sub`=9 pops the status word. It completes with `flags_we`=1, `flags`=loaded bits [3:0], `wb_we`=0 and `sp_data`=R15+4. Opcode 0x17 with `iss_sub`=9 pushes `ps_val`. No other instruction asserts `flags_we`.
- R11: Any other opcode, or 0x07/0x17 with a sub-code other than 0 or 9, starts no request, leaves `iss_ready` high and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | Instruction presented |
| iss_ready | output | 1 | Unit idle, can accept |
| iss_opc | input | 8 | Primary opcode |
| iss_sub | input | 4 | Sub-code for stack forms |
| iss_ri | input | 4 | Destination register index |
| iss_off | input | 8 | Raw offset field |
| rj_val | input | 32 | Value of Rj |
| r13_val | input | 32 | Value of R13 |
| r14_val | input | 32 | Value of R14 |
| r15_val | input | 32 | Value of R15 (stack pointer) |
| ri_val | input | 32 | Store source register value |
| ps_val | input | 32 | Status word for push |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_ready | input | 1 | Memory completes request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Completion pulse |
| wb_we | output | 1 | Register writeback enable |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 32 | Zero-extended load value |
| sp_we | output | 1 | Stack pointer update enable |
| sp_data | output | 32 | New stack pointer |
| flags_we | output | 1 | Condition flag update enable |
| flags | output | 4 | New NZVC flags |

## Verification
A fixed-seed random mix of every legal opcode is driven with random register values, offsets, read data and memory latencies. This separates the base register chosen by each form, the offset scaling per size, the lane selection and the zero-extension. Directed cases then cover sign-negative R14 offsets, misaligned bases that must be cleared, all four byte offsets, push and pop at a wrapping stack pointer, and both status-word forms, which tell the flag path apart from the register path. Illegal opcodes and sub-codes are driven to show that no request starts. Operand inputs are scrambled after acceptance to confirm they were latched.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;
   typedef enum logic [2:0] {AM_RJ, AM_R13, AM_R14, AM_R15D, AM_POP, AM_PUSH} amode_e;
   typedef struct packed {
      logic   ok;
      logic   store;
      logic   ps;
      size_e  size;
      amode_e mode;
   } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [7:0] opc,
   input  logic [3:0] sub,
   output dec_t       d
);
   always_comb begin
      d       = '0;
      d.size  = SZ_W;
      d.mode  = AM_RJ;
      d.store = opc[4];
      case (opc[7:4])
         4'h0, 4'h1: begin
            case (opc[3:0])
               4'h0: begin d.ok = 1'b1; d.mode = AM_R13; d.size = SZ_W; end
               4'h1: begin d.ok = 1'b1; d.mode = AM_R13; d.size = SZ_H; end
               4'h2: begin d.ok = 1'b1; d.mode = AM_R13; d.size = SZ_B; end
               4'h3: begin d.ok = 1'b1; d.mode = AM_R15D; d.size = SZ_W; end
               4'h4: begin d.ok = 1'b1; d.mode = AM_RJ; d.size = SZ_W; end
               4'h5: begin d.ok = 1'b1; d.mode = AM_RJ; d.size = SZ_H; end
               4'h6: begin d.ok = 1'b1; d.mode = AM_RJ; d.size = SZ_B; end
               4'h7: begin
                  d.ok   = (sub == 4'd0) || (sub == 4'd9);
                  d.ps   = (sub == 4'd9);
                  d.mode = opc[4] ? AM_PUSH : AM_POP;
               end
               default: d.ok = 1'b0;
            endcase
         end
         4'h2, 4'h3: begin d.ok = 1'b1; d.mode = AM_R14; d.size = SZ_W; end
         4'h4, 4'h5: begin d.ok = 1'b1; d.mode = AM_R14; d.size = SZ_H; end
         4'h6, 4'h7: begin d.ok = 1'b1; d.mode = AM_R14; d.size = SZ_B; end
         default: d.ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 8,
   parameter int UOFF_W = 4
) (
   input  amode_e            mode,
   input  size_e             size,
   input  logic [OFF_W-1:0]  off,
   input  logic [ADDR_W-1:0] rj,
   input  logic [ADDR_W-1:0] r13,
   input  logic [ADDR_W-1:0] r14,
   input  logic [ADDR_W-1:0] r15,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] sp_next
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   logic [ADDR_W-1:0] sdisp, udisp, raw;

   always_comb begin
      sdisp = ADDR_W'($signed(off));
      case (size)
         SZ_W:    sdisp = sdisp << 2;
         SZ_H:    sdisp = sdisp << 1;
         default: sdisp = sdisp;
      endcase
      udisp = ADDR_W'(off[UOFF_W-1:0]) << 2;
      case (mode)
         AM_R13:  raw = r13 + rj;
         AM_R14:  raw = r14 + sdisp;
         AM_R15D: raw = r15 + udisp;
         AM_POP:  raw = r15;
         AM_PUSH: raw = r15 - STEP;
         default: raw = rj;
      endcase
      addr = raw;
      if (size == SZ_W) addr[1:0] = 2'b00;
      if (size == SZ_H) addr[0]   = 1'b0;
      case (mode)
         AM_POP:  sp_next = r15 + STEP;
         AM_PUSH: sp_next = r15 - STEP;
         default: sp_next = r15;
      endcase
   end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
   import lsu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  size_e             size,
   input  logic [1:0]        lsb,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] rdata,
   output logic [3:0]        be,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ldata
);
   logic [1:0] lane;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign lane = ~lsb;
      end else begin : g_little
         assign lane = lsb;
      end
   endgenerate

   always_comb begin
      case (size)
         SZ_B: begin
            be    = 4'b0001 << lane;
            wdata = {4{src[7:0]}};
            ldata = {24'd0, rdata[{lane, 3'b000} +: 8]};
         end
         SZ_H: begin
            be    = lane[1] ? 4'b1100 : 4'b0011;
            wdata = {2{src[15:0]}};
            ldata = {16'd0, (lane[1] ? rdata[31:16] : rdata[15:0])};
         end
         default: begin
            be    = 4'hF;
            wdata = src;
            ldata = rdata;
         end
      endcase
   end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
   import lsu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int OFF_W      = 8,
   parameter int UOFF_W     = 4,
   parameter int IDX_W      = 4,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [7:0]        iss_opc,
   input  logic [3:0]        iss_sub,
   input  logic [IDX_W-1:0]  iss_ri,
   input  logic [OFF_W-1:0]  iss_off,
   input  logic [DATA_W-1:0] rj_val,
   input  logic [DATA_W-1:0] r13_val,
   input  logic [DATA_W-1:0] r14_val,
   input  logic [DATA_W-1:0] r15_val,
   input  logic [DATA_W-1:0] ri_val,
   input  logic [DATA_W-1:0] ps_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              wb_we,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_data,
   output logic              flags_we,
   output logic [3:0]        flags
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("lsu_unit: DATA_W must be 32");
      end
      if (ADDR_W > DATA_W || ADDR_W < OFF_W + 2) begin : g_bad_addr
         $error("lsu_unit: ADDR_W out of range");
      end
      if (UOFF_W > OFF_W) begin : g_bad_off
         $error("lsu_unit: UOFF_W exceeds OFF_W");
      end
   endgenerate

   dec_t              dec;
   logic [ADDR_W-1:0] ea, sp_nx;
   logic              busy, accept;
   logic              q_store, q_ps, q_sp;
   size_e             q_size;
   logic [ADDR_W-1:0] q_addr, q_sp_val;
   logic [DATA_W-1:0] q_src, ldata;
   logic [IDX_W-1:0]  q_idx;

   lsu_decode u_dec (.opc(iss_opc), .sub(iss_sub), .d(dec));

   lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .UOFF_W(UOFF_W)) u_agen (
      .mode(dec.mode), .size(dec.size), .off(iss_off),
      .rj(rj_val[ADDR_W-1:0]), .r13(r13_val[ADDR_W-1:0]),
      .r14(r14_val[ADDR_W-1:0]), .r15(r15_val[ADDR_W-1:0]),
      .addr(ea), .sp_next(sp_nx)
   );

   lsu_lane #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .size(q_size), .lsb(q_addr[1:0]), .src(q_src), .rdata(mem_rdata),
      .be(mem_be), .wdata(mem_wdata), .ldata(ldata)
   );

   assign accept    = iss_valid && !busy && dec.ok;
   assign iss_ready = !busy;
   assign mem_req   = busy;
   assign mem_we    = q_store;
   assign mem_addr  = q_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         q_store  <= 1'b0;
         q_ps     <= 1'b0;
         q_sp     <= 1'b0;
         q_size   <= SZ_W;
         q_addr   <= '0;
         q_sp_val <= '0;
         q_src    <= '0;
         q_idx    <= '0;
         done     <= 1'b0;
         wb_we    <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
         sp_we    <= 1'b0;
         sp_data  <= '0;
         flags_we <= 1'b0;
         flags    <= '0;
      end else begin
         done     <= 1'b0;
         wb_we    <= 1'b0;
         sp_we    <= 1'b0;
         flags_we <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            q_store  <= dec.store;
            q_ps     <= dec.ps;
            q_sp     <= (dec.mode == AM_POP) || (dec.mode == AM_PUSH);
            q_size   <= dec.size;
            q_addr   <= ea;
            q_sp_val <= sp_nx;
            q_src    <= dec.ps ? ps_val : ri_val;
            q_idx    <= iss_ri;
         end else if (busy && mem_ready) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            wb_we    <= !q_store && !q_ps;
            wb_idx   <= q_idx;
            sp_we    <= q_sp;
            sp_data  <= DATA_W'(q_sp_val);
            if (!q_store) wb_data <= ldata;
            if (!q_store && q_ps) begin
               flags_we <= 1'b1;
               flags    <= mem_rdata[3:0];
            end
         end
      end
   end

   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_we));
   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> done && !mem_req);
   // R7
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_be == 4'hF |-> mem_addr[1:0] == 2'b00);
   // R8
   be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2)
                  || ($countones(mem_be) == 4));
   // R10
   flags_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> done && !wb_we && sp_we);
   // R6
   sp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> done);
endmodule

// File: tb/lsu_unit_tb.sv
module lsu_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic        iss_ready;
   logic [7:0]  iss_opc = '0;
   logic [3:0]  iss_sub = '0;
   logic [3:0]  iss_ri = '0;
   logic [7:0]  iss_off = '0;
   logic [31:0] rj_val = '0, r13_val = '0, r14_val = '0, r15_val = '0;
   logic [31:0] ri_val = '0, ps_val = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, wb_we, sp_we, flags_we;
   logic [3:0]  wb_idx, flags;
   logic [31:0] wb_data, sp_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   lsu_unit dut_i (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_opc(iss_opc), .iss_sub(iss_sub), .iss_ri(iss_ri), .iss_off(iss_off),
      .rj_val(rj_val), .r13_val(r13_val), .r14_val(r14_val), .r15_val(r15_val),
      .ri_val(ri_val), .ps_val(ps_val), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done), .wb_we(wb_we),
      .wb_idx(wb_idx), .wb_data(wb_data), .sp_we(sp_we), .sp_data(sp_data),
      .flags_we(flags_we), .flags(flags)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // Expected behaviour derived from the requirements
   task automatic model(input logic [7:0] opc, input logic [3:0] sub, input logic [7:0] off,
                        input logic [31:0] rj, r13, r14, r15, riv, psv, rd,
                        output logic legal, output logic st, output logic [31:0] addr,
                        output logic [3:0] be, output logic [31:0] wd,
                        output logic spw, output logic [31:0] spd,
                        output logic wbw, output logic [31:0] wbd,
                        output logic fw, output logic [3:0] fl, output string tag);
      int sz;  // 0 byte, 1 half, 2 word
      logic ps;
      logic [31:0] src;
      logic [1:0]  a;
      legal = 1'b1; st = opc[4]; sz = 2; ps = 1'b0; spw = 1'b0; spd = r15;
      addr = rj; tag = "R2";
      if (opc[7:4] <= 4'h1) begin
         case (opc[3:0])
            4'h0: begin addr = r13 + rj; sz = 2; end
            4'h1: begin addr = r13 + rj; sz = 1; end
            4'h2: begin addr = r13 + rj; sz = 0; end
            4'h3: begin addr = r15 + {26'd0, off[3:0], 2'b00}; sz = 2; tag = "R4"; end
            4'h4: begin addr = rj; sz = 2; end
            4'h5: begin addr = rj; sz = 1; end
            4'h6: begin addr = rj; sz = 0; end
            4'h7: begin
               legal = (sub == 4'd0) || (sub == 4'd9);
               ps = (sub == 4'd9);
               spw = 1'b1;
               if (st) begin addr = r15 - 32'd4; spd = r15 - 32'd4; tag = ps ? "R10" : "R6"; end
               else    begin addr = r15;         spd = r15 + 32'd4; tag = ps ? "R10" : "R5"; end
            end
            default: legal = 1'b0;
         endcase
      end else if (opc[7:4] <= 4'h7) begin
         tag = "R3";
         sz = (opc[7:4] <= 4'h3) ? 2 : (opc[7:4] <= 4'h5) ? 1 : 0;
         addr = r14 + ({{24{off[7]}}, off} << sz);
      end else legal = 1'b0;
      if (sz == 2) addr[1:0] = 2'b00;
      if (sz == 1) addr[0] = 1'b0;
      a = addr[1:0];
      src = ps ? psv : riv;
      case (sz)
         0: begin be = 4'b1000 >> a; wd = {4{src[7:0]}}; wbd = {24'd0, rd[8*(3-a) +: 8]}; end
         1: begin be = a[1] ? 4'b0011 : 4'b1100; wd = {2{src[15:0]}};
                  wbd = {16'd0, (a[1] ? rd[15:0] : rd[31:16])}; end
         default: begin be = 4'hF; wd = src; wbd = rd; end
      endcase
      wbw = !st && !ps;
      fw  = !st && ps;
      fl  = rd[3:0];
   endtask

   task automatic run_op(input logic [7:0] opc, input logic [3:0] sub, input logic [3:0] ri,
                         input logic [7:0] off, input logic [31:0] rj, r13, r14, r15,
                         input int lat);
      logic legal, st, spw, wbw, fw;
      logic [31:0] addr, wd, spd, wbd, riv, psv, rd;
      logic [3:0] be, fl;
      string tag;
      riv = $urandom; psv = $urandom; rd = $urandom;
      model(opc, sub, off, rj, r13, r14, r15, riv, psv, rd,
            legal, st, addr, be, wd, spw, spd, wbw, wbd, fw, fl, tag);
      @(negedge clk);
      iss_valid = 1'b1; iss_opc = opc; iss_sub = sub; iss_ri = ri; iss_off = off;
      rj_val = rj; r13_val = r13; r14_val = r14; r15_val = r15; ri_val = riv; ps_val = psv;
      chk("R1", "iss_ready idle", {31'd0, iss_ready}, 32'd1);
      @(negedge clk);
      iss_valid = 1'b0;
      rj_val = $urandom; r13_val = $urandom; r14_val = $urandom; r15_val = $urandom;
      ri_val = $urandom; ps_val = $urandom; iss_off = $urandom;
      if (!legal) begin
         chk("R11", "mem_req", {31'd0, mem_req}, 32'd0);
         chk("R11", "iss_ready", {31'd0, iss_ready}, 32'd1);
         @(negedge clk);
         chk("R11", "done", {31'd0, done}, 32'd0);
         return;
      end
      chk("R1", "mem_req", {31'd0, mem_req}, 32'd1);
      chk("R1", "iss_ready busy", {31'd0, iss_ready}, 32'd0);
      chk(tag, "mem_addr", mem_addr, addr);
      chk("R8", "mem_be", {28'd0, mem_be}, {28'd0, be});
      chk("R8", "mem_we", {31'd0, mem_we}, {31'd0, st});
      if (st) chk("R8", "mem_wdata", mem_wdata, wd);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         chk("R1", "addr held", mem_addr, addr);
         chk("R1", "no early done", {31'd0, done}, 32'd0);
      end
      mem_ready = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = $urandom;
      chk("R1", "done", {31'd0, done}, 32'd1);
      chk("R1", "req dropped", {31'd0, mem_req}, 32'd0);
      chk("R9", "wb_we", {31'd0, wb_we}, {31'd0, wbw});
      if (wbw) begin
         chk("R9", "wb_idx", {28'd0, wb_idx}, {28'd0, ri});
         chk("R9", "wb_data", wb_data, wbd);
      end
      chk("R6", "sp_we", {31'd0, sp_we}, {31'd0, spw});
      if (spw) chk(tag, "sp_data", sp_data, spd);
      chk("R10", "flags_we", {31'd0, flags_we}, {31'd0, fw});
      if (fw) chk("R10", "flags", {28'd0, flags}, {28'd0, fl});
      @(negedge clk);
      chk("R1", "done pulse", {31'd0, done}, 32'd0);
   endtask

   function automatic logic [7:0] pick_opc();
      int r;
      r = int'($urandom % 10);
      if (r < 5) return 8'((($urandom % 2) << 4) | ($urandom % 7));
      if (r == 5) return ($urandom % 2) ? 8'h17 : 8'h07;
      return 8'(((($urandom % 6) + 2) << 4) | ($urandom % 16));
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", "reset iss_ready", {31'd0, iss_ready}, 32'd1);
      chk("R1", "reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1", "reset done", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_op(8'h04, 4'd0, 4'd3, 8'h00, 32'h1000_0007, 0, 0, 0, 0);          // R2, R7 word clear
      run_op(8'h00, 4'd0, 4'd4, 8'h00, 32'h0000_0010, 32'h2000_0003, 0, 0, 2); // R2 R13 indexed
      run_op(8'h15, 4'd0, 4'd1, 8'h00, 32'h0000_0103, 0, 0, 0, 1);          // R7 half store
      run_op(8'h2A, 4'd0, 4'd5, 8'hFF, 0, 0, 32'h0000_1000, 0, 0);          // R3 negative word
      run_op(8'h4A, 4'd0, 4'd5, 8'h80, 0, 0, 32'h0000_1000, 0, 0);          // R3 half -128
      run_op(8'h7A, 4'd0, 4'd5, 8'h7F, 0, 0, 32'h0000_1000, 0, 0);          // R3 byte +127
      run_op(8'h03, 4'd0, 4'd6, 8'hFF, 0, 0, 0, 32'h0000_8000, 1);          // R4 only low nibble
      run_op(8'h13, 4'd0, 4'd6, 8'h0F, 0, 0, 0, 32'h0000_8000, 0);          // R4
      run_op(8'h07, 4'd0, 4'd2, 8'h00, 0, 0, 0, 32'hFFFF_FFFC, 0);          // R5 wrap
      run_op(8'h17, 4'd0, 4'd2, 8'h00, 0, 0, 0, 32'h0000_0000, 0);          // R6 wrap
      run_op(8'h07, 4'd9, 4'd2, 8'h00, 0, 0, 0, 32'h0000_4000, 1);          // R10 pop status
      run_op(8'h17, 4'd9, 4'd2, 8'h00, 0, 0, 0, 32'h0000_4000, 0);          // R10 push status
      for (int a = 0; a < 4; a++) begin
         run_op(8'h06, 4'd0, 4'd7, 8'h00, 32'h0000_0200 + a, 0, 0, 0, 0);   // R9 byte lanes
         run_op(8'h16, 4'd0, 4'd7, 8'h00, 32'h0000_0200 + a, 0, 0, 0, 0);   // R8 byte lanes
         run_op(8'h05, 4'd0, 4'd7, 8'h00, 32'h0000_0200 + a, 0, 0, 0, 0);   // R9 half lanes
      end
      // R11 illegal forms
      run_op(8'h08, 4'd0, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      run_op(8'h1F, 4'd0, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      run_op(8'h80, 4'd0, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      run_op(8'hF3, 4'd0, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      run_op(8'h07, 4'd5, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      run_op(8'h17, 4'd8, 4'd0, 8'h00, 0, 0, 0, 0, 0);
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] o;
         o = pick_opc();
         run_op(o, (($urandom % 2) != 0) ? 4'd9 : 4'd0, 4'($urandom), 8'($urandom),
                $urandom, $urandom, $urandom, $urandom, int'($urandom % 4));
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule